// File: doc/BRIEF.md
# Clock-Gated Moore State Machine

A four-state Moore controller whose state register is clocked only when the machine is about to leave its present state. A separate activation function looks at the present state and the input vector. When that pair names a self-loop of the state graph, the function drops the clock enable, and the register keeps its value for that cycle. The outputs are decoded from the state alone, so they cannot change while the clock is stopped.

The gate is modelled as a clock enable. A level-sensitive latch that is open while the clock is low captures the enable value present just before each rising edge. A plain enable sampled at that edge gives the same result, and that is the form used here. A saturating counter counts the cycles in which the clock was suppressed. This lets the gating rate be observed at the ports.

Top module: `gated_moore_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is IDLE (code 0) and `skip_cnt` becomes 0, whatever `in_vec` holds. During reset, `clk_en` is forced to 1.
- R2: Input bits: go = `in_vec[0]`, stop = `in_vec[1]`. State codes: IDLE=0, ARM=1, RUN=2, DONE=3. The transitions are:
  - IDLE goes to ARM on go and stays otherwise.
  - ARM always goes to RUN.
  - RUN goes to DONE on stop and stays otherwise.
  - DONE stays while go is high and returns to IDLE when go is low.
- R3: `moore_out` depends on the state only: IDLE gives 3'b001, ARM and RUN give 3'b010, DONE gives 3'b100.
- R4: Outside reset, `clk_en` is 0 for exactly these (state, input) pairs: IDLE with go low, RUN with stop low, DONE with go high. It is 1 for every other pair.
- R5: In a cycle with `clk_en` low, `state_q` and `moore_out` keep their values across the next edge.
- R6: Each edge with `clk_en` low adds one to `skip_cnt`. The counter stops at its maximum value, 2^CNT_W-1.
- R7: Outside reset, an edge with `clk_en` high always moves the machine to a different state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vec | input | 2 | Primary inputs: bit 0 go, bit 1 stop |
| state_q | output | 2 | Present state code |
| moore_out | output | 3 | Decoded Moore outputs |
| clk_en | output | 1 | Clock activation for the state register |
| skip_cnt | output | CNT_W | Saturating count of suppressed cycles |

## Verification
The bench drives these input patterns:
- An idle dwell with go low, which tests gating in IDLE.
- A full IDLE-ARM-RUN-DONE-IDLE pass with short and long dwells in RUN and DONE.
- Patterns that raise go in RUN and stop in IDLE, which separate the bit that matters in each state from the bit that does not.
- A reset issued mid-run with go held high.

A long idle dwell drives the counter into saturation. Each cycle, a behavioural reference machine with no gating predicts the state, the outputs, the enable and the count. This catches both a missed suppression and a clock stopped on a real transition.

// File: rtl/gmf_pkg.sv
package gmf_pkg;
    localparam int IN_W     = 2;
    localparam int OUT_W    = 3;
    localparam int GO_BIT   = 0;
    localparam int STOP_BIT = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } gmf_state_e;
endpackage

// File: rtl/gmf_next_state.sv
module gmf_next_state
    import gmf_pkg::*;
(
    input  gmf_state_e            cur,
    input  logic [IN_W-1:0]       in_vec,
    output gmf_state_e            nxt
);
    // R2 transition graph
    always_comb begin
        nxt = cur;
        case (cur)
            ST_IDLE: if (in_vec[GO_BIT])   nxt = ST_ARM;
            ST_ARM:                        nxt = ST_RUN;
            ST_RUN:  if (in_vec[STOP_BIT]) nxt = ST_DONE;
            ST_DONE: if (!in_vec[GO_BIT])  nxt = ST_IDLE;
            default:                       nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/gmf_activation.sv
module gmf_activation
    import gmf_pkg::*;
(
    input  gmf_state_e            cur,
    input  logic [IN_W-1:0]       in_vec,
    input  logic                  rst,
    output logic                  en
);
    logic self_loop;

    // R4: enumerate self-loop (state, input) pairs directly
    always_comb begin
        self_loop = 1'b0;
        case (cur)
            ST_IDLE: self_loop = !in_vec[GO_BIT];
            ST_RUN:  self_loop = !in_vec[STOP_BIT];
            ST_DONE: self_loop = in_vec[GO_BIT];
            default: self_loop = 1'b0;
        endcase
        en = rst || !self_loop;   // R1: reset forces the enable
    end
endmodule

// File: rtl/gmf_out_dec.sv
module gmf_out_dec
    import gmf_pkg::*;
(
    input  gmf_state_e            cur,
    output logic [OUT_W-1:0]      outs
);
    // R3 Moore decode
    always_comb begin
        case (cur)
            ST_IDLE:        outs = 3'b001;
            ST_ARM, ST_RUN: outs = 3'b010;
            ST_DONE:        outs = 3'b100;
            default:        outs = 3'b001;
        endcase
    end
endmodule

// File: rtl/gated_moore_fsm.sv
module gated_moore_fsm
    import gmf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            in_vec,
    output logic [1:0]            state_q,
    output logic [2:0]            moore_out,
    output logic                  clk_en,
    output logic [CNT_W-1:0]      skip_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        gmf_state_e       state;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t      r_d, r_q;
    gmf_state_e nxt_state;
    logic       en;

    gmf_next_state u_next (.cur(r_q.state), .in_vec(in_vec), .nxt(nxt_state));
    gmf_activation u_act  (.cur(r_q.state), .in_vec(in_vec), .rst(rst), .en(en));
    gmf_out_dec    u_dec  (.cur(r_q.state), .outs(moore_out));

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
        end else if (en) begin
            r_d.state = nxt_state;      // register receives a clock pulse
        end else if (r_q.cnt != CNT_MAX) begin
            r_d.cnt   = r_q.cnt + 1'b1; // suppressed cycle counted
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_q  = r_q.state;
    assign clk_en   = en;
    assign skip_cnt = r_q.cnt;

    assert_reset_load_R1: assert property (@(posedge clk)
        rst |=> (state_q == 2'd0) && (skip_cnt == '0));

    assert_hold_when_gated_R5: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(state_q) && $stable(moore_out));

    assert_enable_moves_R7: assert property (@(posedge clk) disable iff (rst)
        clk_en |=> state_q != $past(state_q));

    assert_skip_count_R6: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && skip_cnt != CNT_MAX) |=> skip_cnt == CNT_W'($past(skip_cnt) + 1'b1));

    assert_skip_sat_R6: assert property (@(posedge clk) disable iff (rst)
        (skip_cnt == CNT_MAX) |=> skip_cnt == CNT_MAX);

    assert_outputs_decoded_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(moore_out) == 1);
endmodule

// File: tb/gated_moore_fsm_test.sv
module gated_moore_fsm_test;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    in_vec = 2'b00;
    logic [1:0]    state_q;
    logic [2:0]    moore_out;
    logic          clk_en;
    logic [CW-1:0] skip_cnt;

    int errors = 0;
    int checks = 0;
    int ref_state = 0;
    int ref_cnt = 0;

    gated_moore_fsm #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .in_vec(in_vec), .state_q(state_q),
        .moore_out(moore_out), .clk_en(clk_en), .skip_cnt(skip_cnt)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic int ref_next(int s, logic [1:0] iv);
        if (s == 0) return iv[0] ? 1 : 0;
        if (s == 1) return 2;
        if (s == 2) return iv[1] ? 3 : 2;
        return iv[0] ? 3 : 0;
    endfunction

    function automatic int ref_out(int s);
        if (s == 0) return 1;
        if (s == 3) return 4;
        return 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive after negedge, check enable before edge, state after edge
    task automatic step(logic r, logic [1:0] iv, string tag);
        int nx;
        logic exp_en;
        @(negedge clk);
        rst = r;
        in_vec = iv;
        #5;
        nx = ref_next(ref_state, iv);
        exp_en = r || (nx != ref_state);
        check({tag, " R4 clk_en"}, int'(clk_en), int'(exp_en));
        @(posedge clk);
        if (r) begin
            ref_state = 0;
            ref_cnt = 0;
        end else if (exp_en) begin
            ref_state = nx;
        end else if (ref_cnt != CMAX) begin
            ref_cnt++;
        end
        #5;
        check({tag, " R2 state"}, int'(state_q), ref_state);
        check({tag, " R3 outputs"}, int'(moore_out), ref_out(ref_state));
        check({tag, " R6 skip_cnt"}, int'(skip_cnt), ref_cnt);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset with go held high still loads IDLE
        step(1'b1, 2'b01, "R1 reset go");
        step(1'b1, 2'b11, "R1 reset both");
        // idle dwell, stop bit irrelevant in IDLE (R4)
        step(1'b0, 2'b00, "idle dwell");
        step(1'b0, 2'b10, "idle stop only");
        // full pass with R5 holds in RUN
        step(1'b0, 2'b01, "go");
        step(1'b0, 2'b00, "arm");
        step(1'b0, 2'b01, "run go ignored");
        step(1'b0, 2'b00, "run hold");
        step(1'b0, 2'b10, "stop");
        step(1'b0, 2'b01, "done hold R5");
        step(1'b0, 2'b11, "done hold");
        step(1'b0, 2'b00, "done exit");
        // R7 short pass: ARM leaves even with no inputs
        step(1'b0, 2'b01, "go2");
        step(1'b0, 2'b10, "arm2");
        step(1'b0, 2'b10, "stop2");
        step(1'b0, 2'b10, "done exit2");
        // mid-run reset R1
        step(1'b0, 2'b01, "go3");
        step(1'b0, 2'b01, "arm3");
        step(1'b1, 2'b01, "R1 mid reset");
        // R6 saturation with a long idle dwell
        for (int i = 0; i < 20; i++) step(1'b0, 2'b00, "R6 saturate");
        step(1'b0, 2'b01, "leave after sat");
        step(1'b0, 2'b00, "arm after sat");
        step(1'b0, 2'b00, "run after sat");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule